// File: doc/BRIEF.md
# Integer ALU with Status Flags

This unit performs the integer arithmetic, logic, shift and upper-immediate operations of a small 32-bit load-store processor, and holds the four status flags: negative, zero, overflow and carry. The operation is picked by a 6-bit operation code. The second operand arrives already chosen by the datapath: it is either a register value or a sign-extended immediate. A separate 22-bit field supplies the upper-immediate value.

The result and the illegal-code indication are combinational, so they are valid in the same cycle as the inputs. The flags are held in a register. They change only at a rising clock edge where the execute strobe is high and the operation is one of the flag-setting kind. Branch logic elsewhere reads the registered flags.

Top module: `alu_cc_unit`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the flags output is 0. The flags output packs negative, zero, overflow and carry into bits 3, 2, 1 and 0.
- R2: Code 010000 adds A and B modulo 2^32. On an executed edge it loads the flags as follows: carry is the carry out of bit 31, overflow is set on signed overflow, negative is result bit 31, and zero is set when the result is 0.
- R3: Code 010001 gives A AND B. On an executed edge, negative and zero follow the result, and overflow and carry are cleared.
- R4: Code 010010 gives A OR B, with the same flag rule as R3.
- R5: Code 010110 gives the complement of (A OR B), with the same flag rule as R3.
- R6: Code 100110 shifts A right, filling with zeros, by the amount in B bits 4..0. B bits 31..5 have no effect on the result.
- R7: Code 100100 places the 22-bit immediate in result bits 31..10 and zeros bits 9..0. A, B and the flags are not affected.
- R8: The flags change only at a rising edge where the execute strobe is high. With the strobe low they hold their value for any code.
- R9: Any code other than the six listed gives a result of 0, drives the illegal output high and leaves the flags unchanged. The six listed codes drive the illegal output low.
- R10: An executed shift (code 100110) leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; enables the flag update |
| opcode_i | input | 6 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register or extended immediate) |
| imm22_i | input | 22 | Upper-immediate value |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Registered {n, z, v, c} |
| illegal_o | output | 1 | Unrecognised operation code |

## Verification
The result and the illegal flag have no register in their path, so they are due in the same cycle as the inputs. The bench drives the inputs on the falling edge and samples these outputs one time unit later. The flags pass through one register, so they are sampled on the falling edge after the next rising edge. The bench compares them there with a flag model that it updates only for executed flag-setting codes.

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int DW   = 32,
  parameter int IMMW = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_i,
  input  logic [5:0]      opcode_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [IMMW-1:0] imm22_i,
  output logic [DW-1:0]   result_o,
  output logic [3:0]      flags_o,
  output logic            illegal_o
);
  localparam int SHW = $clog2(DW);
  localparam logic [5:0] OP_ADD   = 6'b010000;
  localparam logic [5:0] OP_AND   = 6'b010001;
  localparam logic [5:0] OP_OR    = 6'b010010;
  localparam logic [5:0] OP_NOR   = 6'b010110;
  localparam logic [5:0] OP_SRL   = 6'b100110;
  localparam logic [5:0] OP_SETHI = 6'b100100;

  logic [DW:0]   add_w;
  logic          add_v;
  logic          cc_op;
  logic [1:0]    vc_next;

  assign add_w = {1'b0, a_i} + {1'b0, b_i};
  assign add_v = (a_i[DW-1] == b_i[DW-1]) && (add_w[DW-1] != a_i[DW-1]);

  always_comb begin
    result_o  = '0;
    cc_op     = 1'b0;
    vc_next   = 2'b00;
    illegal_o = 1'b0;
    case (opcode_i)
      OP_ADD:   begin result_o = add_w[DW-1:0]; cc_op = 1'b1; vc_next = {add_v, add_w[DW]}; end
      OP_AND:   begin result_o = a_i & b_i;     cc_op = 1'b1; end
      OP_OR:    begin result_o = a_i | b_i;     cc_op = 1'b1; end
      OP_NOR:   begin result_o = ~(a_i | b_i);  cc_op = 1'b1; end
      OP_SRL:   result_o = a_i >> b_i[SHW-1:0];
      OP_SETHI: result_o = {imm22_i, {(DW-IMMW){1'b0}}};
      default:  illegal_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_o <= '0;
    else if (exec_i && cc_op)
      flags_o <= {result_o[DW-1], result_o == '0, vc_next};
  end
endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_i,
  input logic [5:0]  opcode_i,
  input logic [31:0] result_o,
  input logic [3:0]  flags_o,
  input logic        illegal_o
);
  always @(posedge clk)
    if (!rst_n) p_reset_clear_r1: assert (flags_o == 4'b0);

  p_add_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 6'b010000) |=> flags_o[3] == $past(result_o[31]));

  p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (opcode_i == 6'b010001 || opcode_i == 6'b010010 || opcode_i == 6'b010110))
    |=> flags_o[1:0] == 2'b00);

  p_sethi_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i == 6'b100100) |-> result_o[9:0] == 10'b0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(flags_o));

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> result_o == 32'b0);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(flags_o));

  p_shift_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 6'b100110) |=> $stable(flags_o));
endmodule

bind alu_cc_unit alu_cc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
  .result_o(result_o), .flags_o(flags_o), .illegal_o(illegal_o)
);

// File: tb/alu_cc_unit_bench.sv
module alu_cc_unit_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [5:0]  opcode_i = 6'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [21:0] imm22_i = '0;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  logic        illegal_o;

  int checks = 0, errors = 0;
  logic [3:0] exp_flags = 4'b0;
  bit done = 0;

  alu_cc_unit u_alu_cc_unit (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic bit legal(input logic [5:0] op);
    return op inside {6'b010000, 6'b010001, 6'b010010, 6'b010110, 6'b100110, 6'b100100};
  endfunction

  function automatic logic [31:0] model_res(input logic [5:0] op, input logic [31:0] a, b, input logic [21:0] im);
    case (op)
      6'b010000: return a + b;
      6'b010001: return a & b;
      6'b010010: return a | b;
      6'b010110: return ~(a | b);
      6'b100110: return a >> b[4:0];
      6'b100100: return {im, 10'b0};
      default:   return 32'b0;
    endcase
  endfunction

  function automatic logic [3:0] model_flags(input logic [5:0] op, input logic [31:0] a, b, input logic [3:0] old);
    logic [32:0] s;
    logic [31:0] r;
    r = model_res(op, a, b, 22'b0);
    if (op == 6'b010000) begin
      s = {1'b0, a} + {1'b0, b};
      return {r[31], r == 0, (a[31] == b[31]) && (r[31] != a[31]), s[32]};
    end
    if (op inside {6'b010001, 6'b010010, 6'b010110})
      return {r[31], r == 0, 2'b00};
    return old;
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'b010000: return "R2";
      6'b010001: return "R3";
      6'b010010: return "R4";
      6'b010110: return "R5";
      6'b100110: return "R6";
      6'b100100: return "R7";
      default:   return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] op, input logic [31:0] a, b, input logic [21:0] im, input bit ex);
    @(negedge clk);
    opcode_i = op; a_i = a; b_i = b; imm22_i = im; exec_i = ex;
    #1;
    check(tag_of(op), result_o, model_res(op, a, b, im));
    check(legal(op) ? "R9 legal" : "R9 illegal", {31'b0, illegal_o}, {31'b0, !legal(op)});
    if (ex) exp_flags = model_flags(op, a, b, exp_flags);
    @(posedge clk);
    @(negedge clk);
    check(!ex ? "R8 flags" : (op == 6'b100110 ? "R10 flags" : {tag_of(op), " flags"}),
          {28'b0, flags_o}, {28'b0, exp_flags});
    exec_i = 1'b0;
  endtask

  initial begin
    logic [5:0] codes [6];
    codes = '{6'b010000, 6'b010001, 6'b010010, 6'b010110, 6'b100110, 6'b100100};
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 reset", {28'b0, flags_o}, 32'b0);
    rst_n = 1'b1;
    run_op(6'b010000, 32'h7fffffff, 32'h1, 22'h0, 1);
    run_op(6'b010000, 32'hffffffff, 32'h1, 22'h0, 1);
    run_op(6'b010000, 32'h80000000, 32'h80000000, 22'h0, 1);
    run_op(6'b010001, 32'hf0f0f0f0, 32'h0f0f0f0f, 22'h0, 1);
    run_op(6'b010110, 32'h0, 32'h0, 22'h0, 1);
    run_op(6'b010010, 32'h0, 32'h0, 22'h0, 1);
    run_op(6'b100110, 32'h80000000, 32'h0000001f, 22'h0, 1);
    run_op(6'b100110, 32'hdeadbeef, 32'hffffffe3, 22'h0, 1);
    run_op(6'b100110, 32'h12345678, 32'h0, 22'h0, 1);
    run_op(6'b100100, 32'h5, 32'h7, 22'h304f15, 1);
    run_op(6'b000000, 32'hffffffff, 32'hffffffff, 22'h3fffff, 1);
    run_op(6'b111111, 32'h0, 32'h0, 22'h0, 1);
    run_op(6'b010000, 32'h7fffffff, 32'h7fffffff, 22'h0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      int k;
      k = $urandom % 8;
      op = (k < 6) ? codes[k] : 6'($urandom);
      run_op(op, $urandom, $urandom, 22'($urandom), ($urandom % 4) != 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule